// File: doc/BRIEF.md
# Sigma-Delta Test Bitstream Generator

This block produces a one-bit sigma-delta stream from a series of 24-bit signed samples, intended to drive an external test DAC or to exercise a decimation filter without analog input. Each incoming sample is multiplied by a programmable gain, reduced back to sample width and clamped to a stable amplitude. It is then parked in a pending slot until the sample currently in use has been consumed.

A zero-order-hold stage reuses each scaled value for a programmable number of output bit periods, and a second-order error-feedback modulator emits one bit per bit-rate strobe. A gated sync pulse can realign the hold phase to an external event. A select input routes the generated bit into the filter's modulator-data path in place of the external stream, which allows loopback testing.

Top module: `sdm_testgen`

## Requirements
- R1: The value handed to the modulator is (sample × gain) with both signed, arithmetically shifted right by 23 and clamped to the range -0x04FFFF..+0x04FFFF.
- R2: With hold field N, the value in use drives N+1 consecutive bit strobes. At the strobe that ends the run, the pending value, if one exists, replaces it and the count restarts. If no value is pending, the old value keeps being used. If N is lowered below the running count, the run ends at the next strobe.
- R3: A sample that arrives while a value is in use has no effect on the output until the run ends. If several samples arrive in one run, only the latest is kept. A sample accepted in the same cycle as a swap goes into the pending slot and is not used by that swap.
- R4: On each bit strobe the modulator outputs 1 exactly when its second integrator is non-negative. It feeds back +0x0A0000 for a 1 and -0x0A0000 for a 0. The first integrator adds (input − feedback). The second integrator adds (previous first integrator − feedback). Both integrators clamp at ±(2^27−1). The output bit changes one clock after the strobe and holds otherwise.
- R5: A constant input at the positive amplitude ceiling gives a ones density of 75% (within ±0.5% over 400 bits). The negative ceiling gives 25%.
- R6: When sync enable is high, a sync pulse restarts the hold count, and a pending value, if present, is loaded at once. When sync enable is low, sync pulses have no effect.
- R7: The filter data output equals the generated bit when loopback select is 1 and the external modulator bit when it is 0.
- R8: A synchronous active-high reset clears the output bit, both integrators, the value in use, the pending slot and the hold count. While reset is held, the output stays 0 even if strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 24 | Signed input sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| gain_i | input | 24 | Signed gain, 1.0 = 0x800000 (unreachable, max 0x7FFFFF) |
| interp_i | input | 8 | Zero-based hold count per sample |
| bit_stb_i | input | 1 | One-cycle strobe per output bit period |
| sync_en_i | input | 1 | Enables sync realignment |
| sync_i | input | 1 | Sync pulse |
| loop_sel_i | input | 1 | 1 routes generated bit to filter data output |
| ext_mdat_i | input | 1 | External modulator data bit |
| bit_o | output | 1 | Generated sigma-delta bit |
| filt_mdat_o | output | 1 | Selected filter modulator data |

## Verification
The bench targets gain products that overflow the amplitude ceiling in both polarities. A design that wraps instead of clamping would flip the sign and invert the density. Hold values are changed mid-run, including drops below the running count. A design with an equality-only compare would then run on for about 256 strobes before switching samples. Bursts of several samples within one hold window, and samples landing on the swap cycle, expose a pending slot that keeps the oldest value or bypasses the hold. Sync pulses with the enable both set and clear, and some coinciding with strobes, catch sync logic that ignores the gate or fails to load the pending value.

// File: rtl/sdm_tg_pkg.sv
package sdm_tg_pkg;

    localparam int unsigned TG_DW      = 24;
    localparam int unsigned TG_GW      = 24;
    localparam int unsigned TG_IPW     = 8;
    localparam int unsigned TG_IW      = 28;
    localparam int unsigned TG_SHIFT   = 23;
    localparam logic [23:0] TG_LIMIT   = 24'h04FFFF;
    localparam logic [23:0] TG_FB_MAG  = 24'h0A0000;

    // symmetric clamp of a wide signed value
    function automatic logic signed [63:0] sat64(input logic signed [63:0] v,
                                                 input logic signed [63:0] lim);
        if (v > lim)
            return lim;
        else if (v < -lim)
            return -lim;
        else
            return v;
    endfunction

endpackage

// File: rtl/sdm_tg_scale.sv
module sdm_tg_scale
    import sdm_tg_pkg::*;
#(
    parameter int unsigned DW    = TG_DW,
    parameter int unsigned GW    = TG_GW,
    parameter int unsigned SHIFT = TG_SHIFT,
    parameter logic [DW-1:0] LIM = TG_LIMIT
) (
    input  logic [DW-1:0] smp_i,
    input  logic [GW-1:0] gain_i,
    output logic [DW-1:0] scaled_o
);
    localparam int unsigned PW = DW + GW;

    logic signed [PW-1:0] prod;
    logic signed [63:0]   prod_x;
    logic signed [63:0]   shifted;
    logic signed [63:0]   clamped;
    logic signed [63:0]   lim_x;

    always_comb begin
        prod    = $signed(smp_i) * $signed(gain_i);
        prod_x  = {{(64-PW){prod[PW-1]}}, prod};
        shifted = prod_x >>> SHIFT;
        lim_x   = {{(64-DW){1'b0}}, LIM};
        clamped = sat64(shifted, lim_x);
        scaled_o = clamped[DW-1:0];
    end

endmodule

// File: rtl/sdm_tg_hold.sv
module sdm_tg_hold
    import sdm_tg_pkg::*;
#(
    parameter int unsigned DW  = TG_DW,
    parameter int unsigned IPW = TG_IPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  scaled_i,
    input  logic           vld_i,
    input  logic [IPW-1:0] interp_i,
    input  logic           stb_i,
    input  logic           sync_i,
    output logic [DW-1:0]  hold_o,
    output logic [IPW-1:0] cnt_o
);
    typedef struct packed {
        logic [DW-1:0]  pend;
        logic           full;
        logic [DW-1:0]  hold;
        logic [IPW-1:0] cnt;
    } hold_st_t;

    hold_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stb_i) begin
            if (s_q.cnt >= interp_i) begin
                s_d.cnt = '0;
                if (s_q.full) begin
                    s_d.hold = s_q.pend;
                    s_d.full = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (sync_i) begin
            s_d.cnt = '0;
            if (s_q.full) begin
                s_d.hold = s_q.pend;
                s_d.full = 1'b0;
            end
        end
        if (vld_i) begin
            s_d.pend = scaled_i;
            s_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign hold_o = s_q.hold;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/sdm_tg_mod.sv
module sdm_tg_mod
    import sdm_tg_pkg::*;
#(
    parameter int unsigned   DW = TG_DW,
    parameter int unsigned   IW = TG_IW,
    parameter logic [DW-1:0] FB = TG_FB_MAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] x_i,
    input  logic          stb_i,
    output logic          bit_o
);
    localparam logic signed [63:0] IMAX = (64'sd1 <<< (IW-1)) - 64'sd1;

    typedef struct packed {
        logic [IW-1:0] i1;
        logic [IW-1:0] i2;
        logic          bit_v;
    } mod_st_t;

    mod_st_t s_d, s_q;

    logic               y;
    logic signed [63:0] x_x, i1_x, i2_x, fb_x, n1, n2;

    always_comb begin
        s_d  = s_q;
        y    = ~s_q.i2[IW-1];
        x_x  = {{(64-DW){x_i[DW-1]}}, x_i};
        i1_x = {{(64-IW){s_q.i1[IW-1]}}, s_q.i1};
        i2_x = {{(64-IW){s_q.i2[IW-1]}}, s_q.i2};
        fb_x = y ? {{(64-DW){1'b0}}, FB} : -{{(64-DW){1'b0}}, FB};
        n1   = sat64(i1_x + x_x - fb_x, IMAX);
        n2   = sat64(i2_x + i1_x - fb_x, IMAX);
        if (stb_i) begin
            s_d.i1    = n1[IW-1:0];
            s_d.i2    = n2[IW-1:0];
            s_d.bit_v = y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign bit_o = s_q.bit_v;

endmodule

// File: rtl/sdm_testgen.sv
module sdm_testgen
    import sdm_tg_pkg::*;
#(
    parameter int unsigned   DW    = TG_DW,
    parameter int unsigned   GW    = TG_GW,
    parameter int unsigned   IPW   = TG_IPW,
    parameter int unsigned   IW    = TG_IW,
    parameter int unsigned   SHIFT = TG_SHIFT,
    parameter logic [DW-1:0] LIM   = TG_LIMIT,
    parameter logic [DW-1:0] FB    = TG_FB_MAG
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  smp_i,
    input  logic           smp_vld_i,
    input  logic [GW-1:0]  gain_i,
    input  logic [IPW-1:0] interp_i,
    input  logic           bit_stb_i,
    input  logic           sync_en_i,
    input  logic           sync_i,
    input  logic           loop_sel_i,
    input  logic           ext_mdat_i,
    output logic           bit_o,
    output logic           filt_mdat_o
);
    logic [DW-1:0]  scaled;
    logic [DW-1:0]  hold_val;
    logic [IPW-1:0] cnt_val;
    logic           sync_g;
    logic           gen_bit;

    assign sync_g = sync_en_i & sync_i;

    sdm_tg_scale #(.DW(DW), .GW(GW), .SHIFT(SHIFT), .LIM(LIM)) u_scale (
        .smp_i    (smp_i),
        .gain_i   (gain_i),
        .scaled_o (scaled)
    );

    sdm_tg_hold #(.DW(DW), .IPW(IPW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .scaled_i (scaled),
        .vld_i    (smp_vld_i),
        .interp_i (interp_i),
        .stb_i    (bit_stb_i),
        .sync_i   (sync_g),
        .hold_o   (hold_val),
        .cnt_o    (cnt_val)
    );

    sdm_tg_mod #(.DW(DW), .IW(IW), .FB(FB)) u_mod (
        .clk   (clk),
        .rst   (rst),
        .x_i   (hold_val),
        .stb_i (bit_stb_i),
        .bit_o (gen_bit)
    );

    assign bit_o       = gen_bit;
    assign filt_mdat_o = loop_sel_i ? gen_bit : ext_mdat_i;

endmodule

// File: rtl/sdm_testgen_chk.sv
module sdm_testgen_chk #(
    parameter int unsigned   DW  = 24,
    parameter int unsigned   IPW = 8,
    parameter logic [DW-1:0] LIM = 24'h04FFFF
) (
    input logic           clk,
    input logic           rst,
    input logic           bit_stb_i,
    input logic           sync_en_i,
    input logic           sync_i,
    input logic           loop_sel_i,
    input logic           bit_o,
    input logic           filt_mdat_o,
    input logic [DW-1:0]  hold_val,
    input logic [IPW-1:0] cnt_val
);
    logic sync_on;
    assign sync_on = sync_en_i & sync_i;

    // R1: value in use never exceeds the amplitude ceiling
    always_ff @(posedge clk) begin
        if (!rst) begin
            a_r1_hold_in_range: assert ($signed(hold_val) <= $signed(LIM) &&
                                        $signed(hold_val) >= -$signed(LIM))
                else $error("hold value outside ceiling");
        end
    end

    a_r4_bit_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_stb_i |=> $stable(bit_o));

    a_r2_value_steady: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb_i && !sync_on) |=> $stable(hold_val));

    a_r6_sync_restart: assert property (@(posedge clk) disable iff (rst)
        sync_on |=> (cnt_val == '0));

    a_r7_loop_path: assert property (@(posedge clk) disable iff (rst)
        loop_sel_i |-> (filt_mdat_o == bit_o));

endmodule

bind sdm_testgen sdm_testgen_chk #(.DW(DW), .IPW(IPW), .LIM(LIM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_stb_i   (bit_stb_i),
    .sync_en_i   (sync_en_i),
    .sync_i      (sync_i),
    .loop_sel_i  (loop_sel_i),
    .bit_o       (bit_o),
    .filt_mdat_o (filt_mdat_o),
    .hold_val    (hold_val),
    .cnt_val     (cnt_val)
);

// File: tb/sdm_testgen_test.sv
`timescale 1ns/1ps
module sdm_testgen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] smp, gain;
    logic        vld, stb, sync_en, sync_p, loop_sel, ext;
    logic [7:0]  interp;
    logic        bit_o, filt_o;

    int vec = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R8";

    // bench model state
    longint m_pend, m_hold, m_i1, m_i2;
    int     m_cnt;
    bit     m_full, m_bit;

    localparam longint LIMV = 64'h04FFFF;
    localparam longint FBV  = 64'h0A0000;
    localparam longint IMAX = (64'sd1 <<< 27) - 1;

    always #2.5 clk = ~clk;

    sdm_testgen uut (
        .clk(clk), .rst(rst), .smp_i(smp), .smp_vld_i(vld), .gain_i(gain),
        .interp_i(interp), .bit_stb_i(stb), .sync_en_i(sync_en), .sync_i(sync_p),
        .loop_sel_i(loop_sel), .ext_mdat_i(ext), .bit_o(bit_o), .filt_mdat_o(filt_o)
    );

    function automatic longint clampv(longint v, longint lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // R1 expected scaled value
    function automatic longint f_scale(logic [23:0] s, logic [23:0] g);
        longint a, b;
        a = longint'($signed(s));
        b = longint'($signed(g));
        return clampv((a * b) >>> 23, LIMV);
    endfunction

    task automatic model_upd();
        bit y;
        longint fb, n1, n2;
        if (rst) begin
            m_pend = 0; m_hold = 0; m_i1 = 0; m_i2 = 0;
            m_cnt = 0; m_full = 0; m_bit = 0;
            return;
        end
        if (stb) begin
            y  = (m_i2 >= 0);
            fb = y ? FBV : -FBV;
            n1 = clampv(m_i1 + m_hold - fb, IMAX);
            n2 = clampv(m_i2 + m_i1 - fb, IMAX);
            m_i1 = n1; m_i2 = n2; m_bit = y;
        end
        if (stb) begin
            if (m_cnt >= int'(interp)) begin
                m_cnt = 0;
                if (m_full) begin m_hold = m_pend; m_full = 0; end
            end else m_cnt++;
        end
        if (sync_en && sync_p) begin
            m_cnt = 0;
            if (m_full) begin m_hold = m_pend; m_full = 0; end
        end
        if (vld) begin m_pend = f_scale(smp, gain); m_full = 1; end
    endtask

    task automatic check(string req, longint act, longint exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_upd();
        @(negedge clk);
        check(cur_req, bit_o, m_bit);
        check("R7", filt_o, loop_sel ? m_bit : ext);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic density(logic [23:0] s, int lo, int hi, string req);
        int ones = 0;
        do_reset();
        interp = 8'd3; stb = 1'b1;
        smp = s; gain = 24'h7FFFFF; vld = 1'b1;
        step();
        vld = 1'b0;
        repeat (60) step();
        for (int k = 0; k < 400; k++) begin
            step();
            ones += int'(bit_o);
        end
        vec++;
        if (ones < lo || ones > hi) begin
            bad++;
            $display("FAIL %s: actual %0d ones expected %0d..%0d", req, ones, lo, hi);
        end
    endtask

    task automatic rand_run(int n, bit use_sync);
        for (int k = 0; k < n; k++) begin
            stb      = ($urandom % 2) == 0;
            vld      = ($urandom % 6) == 0;
            smp      = 24'($urandom);
            gain     = ($urandom % 4 == 0) ? 24'h7FFFFF : 24'($urandom);
            loop_sel = $urandom % 2;
            ext      = $urandom % 2;
            if ($urandom % 40 == 0) interp = 8'($urandom % 6);
            sync_en  = use_sync ? ($urandom % 2) : 1'b0;
            sync_p   = use_sync ? (($urandom % 8) == 0) : ($urandom % 8 == 0);
            step();
        end
        sync_p = 1'b0; sync_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        smp = '0; gain = '0; vld = 0; stb = 0; sync_en = 0; sync_p = 0;
        loop_sel = 0; ext = 0; interp = 8'd0;

        // R8: reset with strobes present keeps output low
        rst = 1'b1;
        stb = 1'b1; loop_sel = 1'b1;
        repeat (4) step();
        check("R8", bit_o, 0);
        rst = 1'b0; stb = 1'b0; loop_sel = 1'b0;

        // R1: in-range, positive overflow, negative overflow
        cur_req = "R1";
        stb = 1'b1; interp = 8'd0;
        smp = 24'h0A0000; gain = 24'h400000; vld = 1'b1; step(); vld = 1'b0;
        repeat (40) step();
        smp = 24'h7FFFFF; gain = 24'h7FFFFF; vld = 1'b1; step(); vld = 1'b0;
        repeat (40) step();
        smp = 24'h800000; gain = 24'h7FFFFF; vld = 1'b1; step(); vld = 1'b0;
        repeat (40) step();
        smp = 24'h800000; gain = 24'h800000; vld = 1'b1; step(); vld = 1'b0;
        repeat (40) step();

        // R5: density at both ceilings
        cur_req = "R5";
        density(24'h7FFFFF, 298, 302, "R5");
        density(24'h800001, 98, 102, "R5");

        // R3: burst inside a long hold, sample on swap cycle
        cur_req = "R3";
        do_reset();
        interp = 8'd7; stb = 1'b1; gain = 24'h7FFFFF;
        repeat (3) step();
        smp = 24'h200000; vld = 1'b1; step();
        smp = 24'h900000; step();
        smp = 24'h050000; step();
        vld = 1'b0; repeat (2) step();
        smp = 24'h600000; vld = 1'b1; step(); vld = 1'b0;
        repeat (30) step();

        // R2: hold lengths, shrinking hold value mid-run
        cur_req = "R2";
        interp = 8'd9; repeat (6) step();
        interp = 8'd2; repeat (5) step();
        rand_run(3000, 1'b0);

        // R6: gated sync
        cur_req = "R6";
        interp = 8'd5;
        rand_run(3000, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule